// File: doc/BRIEF.md
# Encoded-Ratio Reference Divider

This block divides a crystal reference clock down to the phase-comparison rate of a frequency synthesizer. The divide ratio is not a plain binary count: a 5-bit code picks a base multiplier from its two upper bits and a power-of-two exponent from its three lower bits. Twenty-nine codes are usable. Three codes are illegal and are rejected without disturbing the running ratio. With a 4 MHz reference, the usable ratios cover comparison rates from 31.25 kHz (ratio 128) to 250 kHz (ratio 16) and beyond in both directions.

Software writes the code into a control register, and that register reloads it into the block with a one-cycle strobe. The block outputs a one-cycle comparison pulse once per period and a flag that reports a rejected code. A new ratio never cuts a period short. It is applied at the next period boundary. When test mode selects it, the comparison pulse is routed to a general-purpose port. Otherwise that port shows its ordinary data bit.

Top module: `ref_ratio_div`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the comparison pulse and the invalid-code flag are both 0. The active ratio then equals the decoded value of the reset code parameter, which is code 00000, ratio 2, by default.
- R2: For a code whose upper two bits are 00, the ratio is 2·2^n, where n is the lower three bits. This gives 2, 4, 8 … 256.
- R3: For upper bits 01, 10 and 11 with n from 1 to 7, the ratio is 5·2^(n−1), 6·2^(n−1) and 7·2^(n−1) respectively. This gives maxima of 320, 384 and 448.
- R4: A strobed load of code 01000, 10000 or 11000 sets the invalid-code flag in the next cycle and leaves the pending and active ratios unchanged.
- R5: A strobed load of any legal code clears the invalid-code flag in the next cycle.
- R6: The comparison pulse is exactly one reference cycle wide, and consecutive pulses are exactly the active ratio apart.
- R7: A new ratio first governs the period that starts at the next boundary. A load in the cycle that ends a period already governs the period that follows it.
- R8: The code input is sampled only when the load strobe is high. Changing the code without a strobe alters neither the period nor the flag.
- R9: When the test-select input is 1, the port output shows the comparison pulse. When it is 0, the port output shows the port data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| code_i | input | 5 | Ratio code: [4:3] base select, [2:0] exponent |
| code_ld_i | input | 1 | One-cycle strobe that samples code_i |
| test_sel_i | input | 1 | 1 routes the comparison pulse to port_o |
| port_data_i | input | 1 | Normal value of the shared port |
| cmp_pulse_o | output | 1 | One-cycle comparison pulse, once per period |
| code_bad_o | output | 1 | Set by an illegal code load, cleared by a legal one |
| port_o | output | 1 | Shared port output |

## Verification
The critical coincidence is a code load that lands on the same edge as a period wrap. In that case the new ratio must already govern the period that is just starting. An illegal code arriving on that edge must leave the old ratio in force while it raises the flag. The bench times the strobe from an observed pulse so that it sits in the last cycle of a period, and does this with both legal and illegal codes. A behavioural model then compares every pulse, the flag and the port on every clock. Explicit interval measurements confirm the periods on both sides of the boundary.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  localparam int unsigned BASE_W    = 2;
  localparam int unsigned EXP_W     = 3;
  localparam int unsigned CODE_W    = BASE_W + EXP_W;
  localparam int unsigned RATIO_MAX = 448;
  localparam int unsigned RATIO_W   = $clog2(RATIO_MAX + 1);

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  // Returns {legal, ratio}; illegal codes return all zeros.
  function automatic logic [RATIO_W:0] rdiv_lookup(input code_t c);
    logic [BASE_W-1:0] sel;
    logic [EXP_W-1:0]  e;
    ratio_t            b;
    logic [RATIO_W:0]  res;
    sel = c[CODE_W-1 -: BASE_W];
    e   = c[EXP_W-1:0];
    case (sel)
      2'd0:    b = ratio_t'(2);
      2'd1:    b = ratio_t'(5);
      2'd2:    b = ratio_t'(6);
      default: b = ratio_t'(7);
    endcase
    if (sel == '0)
      res = {1'b1, ratio_t'(b << e)};
    else if (e != '0)
      res = {1'b1, ratio_t'(b << (e - EXP_W'(1)))};
    else
      res = '0;
    return res;
  endfunction
endpackage

// File: rtl/rdiv_decode.sv
module rdiv_decode
  import rdiv_pkg::*;
(
  input  code_t  code_i,
  output ratio_t ratio_o,
  output logic   legal_o
);
  logic [RATIO_W:0] entry;

  always_comb begin
    entry   = rdiv_lookup(code_i);
    legal_o = entry[RATIO_W];
    ratio_o = entry[RATIO_W-1:0];
  end
endmodule

// File: rtl/rdiv_hold.sv
module rdiv_hold
  import rdiv_pkg::*;
#(
  parameter ratio_t RST_RATIO = ratio_t'(2)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  logic   legal_i,
  input  ratio_t ratio_i,
  output ratio_t pend_o,
  output logic   bad_o
);
  ratio_t pend_q, pend_d;
  logic   bad_q, bad_d;

  always_comb begin
    pend_d = pend_q;
    bad_d  = bad_q;
    if (load_i) begin
      if (legal_i) begin
        pend_d = ratio_i;
        bad_d  = 1'b0;
      end else begin
        bad_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RST_RATIO;
      bad_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      bad_q  <= bad_d;
    end
  end

  assign pend_o = pend_q;
  assign bad_o  = bad_q;

  // R4
  bad_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !legal_i |=> bad_o && $stable(pend_o));

  // R5
  bad_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && legal_i |=> !bad_o && (pend_o == $past(ratio_i)));

  // R8
  no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(pend_o) && $stable(bad_o));
endmodule

// File: rtl/rdiv_count.sv
module rdiv_count
  import rdiv_pkg::*;
#(
  parameter ratio_t RST_RATIO = ratio_t'(2)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t next_ratio_i,
  output logic   pulse_o
);
  ratio_t cnt_q, cnt_d;
  ratio_t act_q, act_d;
  logic   pulse_q, pulse_d;
  logic   wrap;

  always_comb begin
    wrap    = (cnt_q == act_q - ratio_t'(1));
    cnt_d   = wrap ? '0 : cnt_q + ratio_t'(1);
    act_d   = wrap ? next_ratio_i : act_q;
    pulse_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= RST_RATIO;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q);

  // R7
  pulse_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (cnt_q == '0));
endmodule

// File: rtl/ref_ratio_div.sv
module ref_ratio_div
  import rdiv_pkg::*;
#(
  parameter code_t RST_CODE = '0
) (
  input  logic              clk_ref_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_ld_i,
  input  logic              test_sel_i,
  input  logic              port_data_i,
  output logic              cmp_pulse_o,
  output logic              code_bad_o,
  output logic              port_o
);
  localparam logic [RATIO_W:0] RST_ENTRY = rdiv_lookup(RST_CODE);
  localparam ratio_t           RST_RATIO = RST_ENTRY[RATIO_W-1:0];

  ratio_t dec_ratio, pend_ratio, next_ratio;
  logic   dec_legal;

  rdiv_decode u_dec (
    .code_i  (code_i),
    .ratio_o (dec_ratio),
    .legal_o (dec_legal)
  );

  rdiv_hold #(.RST_RATIO(RST_RATIO)) u_hold (
    .clk     (clk_ref_i),
    .rst_n   (rst_ni),
    .load_i  (code_ld_i),
    .legal_i (dec_legal),
    .ratio_i (dec_ratio),
    .pend_o  (pend_ratio),
    .bad_o   (code_bad_o)
  );

  // A legal load on the wrap edge feeds the starting period directly.
  always_comb begin
    next_ratio = (code_ld_i && dec_legal) ? dec_ratio : pend_ratio;
  end

  rdiv_count #(.RST_RATIO(RST_RATIO)) u_cnt (
    .clk          (clk_ref_i),
    .rst_n        (rst_ni),
    .next_ratio_i (next_ratio),
    .pulse_o      (cmp_pulse_o)
  );

  always_comb begin
    port_o = test_sel_i ? cmp_pulse_o : port_data_i;
  end
endmodule

// File: tb/sim_ref_ratio_div.sv
module sim_ref_ratio_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] code = '0;
  logic       ld = 1'b0;
  logic       tsel = 1'b0;
  logic       pdat = 1'b0;
  logic       pulse, bad, port;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;
  string phase = "R1";

  int m_cnt, m_act, m_pend, m_bad, m_pulse;

  ref_ratio_div u0 (
    .clk_ref_i   (clk),
    .rst_ni      (rst_n),
    .code_i      (code),
    .code_ld_i   (ld),
    .test_sel_i  (tsel),
    .port_data_i (pdat),
    .cmp_pulse_o (pulse),
    .code_bad_o  (bad),
    .port_o      (port)
  );

  always #5 clk = ~clk;

  function automatic int ref_ratio(input logic [4:0] c);
    int n;
    n = int'(c[2:0]);
    case (c[4:3])
      2'd0: return 2 * (2 ** n);
      2'd1: return (n == 0) ? 0 : 5 * (2 ** (n - 1));
      2'd2: return (n == 0) ? 0 : 6 * (2 ** (n - 1));
      default: return (n == 0) ? 0 : 7 * (2 ** (n - 1));
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural model, advanced on every rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_act = 2; m_pend = 2; m_bad = 0; m_pulse = 0;
    end else begin
      int r;
      bit wrap;
      wrap = (m_cnt == m_act - 1);
      if (ld) begin
        r = ref_ratio(code);
        if (r == 0) m_bad = 1;
        else begin m_pend = r; m_bad = 0; end
      end
      if (wrap) begin m_cnt = 0; m_act = m_pend; end
      else m_cnt++;
      m_pulse = wrap ? 1 : 0;
    end
  end

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk({phase, " pulse"}, int'(pulse), m_pulse);
      chk({phase, " flag"}, int'(bad), m_bad);
      chk("R9 port", int'(port), tsel ? m_pulse : int'(pdat));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic load(input logic [4:0] c);
    @(negedge clk); code = c; ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    #3;
  endtask

  task automatic wait_pulse();
    int g = 0;
    do begin @(negedge clk); #3; g++; end while (!pulse && g < 2000);
    if (g >= 2000) chk({phase, " pulse timeout"}, 0, 1);
  endtask

  task automatic interval(output int n);
    n = 0;
    do begin @(negedge clk); #3; n++; end while (!pulse && n < 2000);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #3;
    chk("R1 pulse in reset", int'(pulse), 0);
    chk("R1 flag in reset", int'(bad), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #3;
    chk("R1 pulse after release", int'(pulse), 0);
    chk("R1 flag after release", int'(bad), 0);
    phase = "R6";
    wait_pulse(); interval(n);
    chk("R1 reset ratio", n, 2);
    chk("R6 width", 1, int'(pulse));
    @(negedge clk); #3;
    chk("R6 one cycle wide", int'(pulse), 0);

    // Sweep of all codes.
    for (int c = 0; c < 32; c++) begin
      int r;
      logic [4:0] cc;
      int prev;
      cc = 5'(c);
      r = ref_ratio(cc);
      phase = (r == 0) ? "R4" : ((cc[4:3] == 2'd0) ? "R2" : "R3");
      prev = m_act;
      load(cc);
      if (r == 0) begin
        chk("R4 flag set", int'(bad), 1);
        wait_pulse(); interval(n);
        chk("R4 ratio kept", n, prev);
      end else begin
        chk({phase, " flag clear"}, int'(bad), 0);
        wait_pulse(); interval(n);
        chk({phase, " period"}, n, r);
      end
    end

    // R5: legal load after an illegal one clears the flag.
    phase = "R5";
    load(5'b10000);
    chk("R5 flag set first", int'(bad), 1);
    load(5'b01001);
    chk("R5 flag cleared", int'(bad), 0);

    // R8: code changes without strobe are ignored.
    phase = "R8";
    wait_pulse();
    code = 5'b11111;
    interval(n);
    chk("R8 period unchanged", n, 5);
    code = 5'b11000;
    interval(n);
    chk("R8 period unchanged 2", n, 5);
    chk("R8 flag unchanged", int'(bad), 0);

    // R7: mid-period load keeps current period.
    phase = "R7";
    wait_pulse();
    @(negedge clk); code = 5'b00011; ld = 1'b1;
    @(negedge clk); ld = 1'b0; #3;
    interval(n);
    chk("R7 current period kept", n + 2, 5);
    interval(n);
    chk("R7 new period", n, 16);

    // R7: load on the wrap edge applies to the following period.
    wait_pulse();
    repeat (15) @(negedge clk);
    code = 5'b01010; ld = 1'b1;
    @(negedge clk); ld = 1'b0; #3;
    chk("R7 boundary pulse", int'(pulse), 1);
    interval(n);
    chk("R7 boundary load period", n, 10);

    // R4 on the boundary: illegal code keeps ratio.
    phase = "R4";
    wait_pulse();
    repeat (9) @(negedge clk);
    code = 5'b11000; ld = 1'b1;
    @(negedge clk); ld = 1'b0; #3;
    chk("R4 boundary flag", int'(bad), 1);
    interval(n);
    chk("R4 boundary ratio kept", n, 10);

    // R9: test routing.
    phase = "R9";
    tsel = 1'b0; pdat = 1'b1;
    @(negedge clk); #3;
    chk("R9 data routed", int'(port), 1);
    tsel = 1'b1;
    wait_pulse();
    chk("R9 pulse routed", int'(port), 1);
    @(negedge clk); #3;
    chk("R9 pulse routed low", int'(port), 0);
    repeat (40) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule